// File: doc/BRIEF.md
# Programmable Window Pulse Generator

This block drives one output pulse whose leading and trailing edges sit at two programmable distances from a common reference moment. A start command marks that moment: it clears a time base counter, captures the two programmed distances and arms the block. The counter advances at a quarter of the fast clock rate, paced by a clock enable rather than a second clock. Two compare channels watch the counter. The first issues a strobe that sets an output latch, and the second issues a strobe that clears it.

Every register runs on the one fast clock, so the delay from a compare match to the output edge is a fixed number of fast cycles and never varies. When the trailing edge has been produced the counter stops and a done flag stays raised until the next start command. The start and end values are plain parallel inputs sampled only on start. No data stream passes through the block, so every pin is a plain control or status signal.

Top module: `pulse_window_gen`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `pulse_o` and `done_o` are both low.
- R2: With start value A below end value B, `pulse_o` goes high in the fast cycle that follows the 4*A+2nd rising clock edge after the edge that samples `start_i` high. This includes A = 0.
- R3: With A below B, `pulse_o` goes low again after edge 4*B+2 counted the same way, so the pulse lasts exactly 4*(B-A) fast cycles.
- R4: When A equals B the set and clear strobes coincide and the clear wins. `pulse_o` stays low throughout and `done_o` rises after edge 4*B+2.
- R5: When B is below A the counter stops at the end match before the start match can occur. `pulse_o` never rises and `done_o` rises after edge 4*B+2.
- R6: `start_val_i` and `end_val_i` are captured only on the edge that samples `start_i` high. Changing them later has no effect on the pulse that is in progress.
- R7: `done_o` rises in the same cycle that `pulse_o` falls, or at the end match when no pulse was produced. It stays high until the next start command clears it.
- R8: A start command that arrives while a window is in progress drives `pulse_o` low on that edge. The new window is then timed from that edge, using the newly captured values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start command; clears the counter and captures both values |
| start_val_i | input | CNT_W | Count at which the output rises |
| end_val_i | input | CNT_W | Count at which the output falls |
| pulse_o | output | 1 | Windowed output pulse |
| done_o | output | 1 | High after the end match until the next start |

## Verification
The main function is swept over every pair of start and end values from 0 to 5. Every fast cycle of each window is compared against the arithmetic edge positions 4*A+2 and 4*B+2. This sweep separates A below B, where the width must be exact, from A equal to B, where the clear must win, and from B below A, where the pulse must never appear. Three further patterns are run. Rewriting the inputs mid-pulse shows whether the values are captured or read live. A restart while the output is high shows whether the start command overrides the latch. A long idle tail shows that done holds until the next start.

// File: rtl/pwg_pkg.sv
package pwg_pkg;
  // Compare channel roles; the clear channel also stops the time base.
  typedef enum logic [0:0] {
    CH_SET = 1'b0,
    CH_CLR = 1'b1
  } pwg_ch_e;

  localparam int unsigned PWG_NUM_CH = 2;
endpackage

// File: rtl/pwg_tick_div.sv
module pwg_tick_div #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic running_i,
  output logic tick_o,
  output logic phase0_o
);
  localparam int unsigned PH_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);

  logic [PH_W-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst || start_i) begin
      phase_q <= '0;
    end else if (running_i) begin
      phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
    end
  end

  assign tick_o   = running_i && (phase_q == PH_LAST);
  assign phase0_o = (phase_q == '0);

  // R2: count enable never fires on two consecutive fast cycles
  p_tick_spaced_r2: assert property (@(posedge clk) disable iff (rst)
    (tick_o && !start_i) |=> !tick_o);
endmodule

// File: rtl/pwg_timebase.sv
module pwg_timebase #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             tick_i,
  input  logic             stop_i,
  output logic             running_o,
  output logic [CNT_W-1:0] count_o
);
  logic             run_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (stop_i) begin
      run_q <= 1'b0;
    end else if (tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign running_o = run_q;
  assign count_o   = cnt_q;

  // R2: count moves only on the enable
  p_count_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !start_i) |=> $stable(cnt_q));
  // R3: once stopped, the time base stays idle until a start
  p_stay_stopped_r3: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !start_i) |=> !run_q);
endmodule

// File: rtl/pwg_cmp_strobe.sv
module pwg_cmp_strobe #(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned STB_LEN = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [CNT_W-1:0] val_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             phase0_i,
  input  logic             running_i,
  output logic             match_o,
  output logic             strobe_o
);
  localparam int unsigned SC_W = $clog2(STB_LEN + 1);

  logic [CNT_W-1:0] cap_q;
  logic [SC_W-1:0]  left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q <= '0;
    end else if (start_i) begin
      cap_q <= val_i;
    end
  end

  assign match_o = running_i && phase0_i && (count_i == cap_q);

  always_ff @(posedge clk) begin
    if (rst || start_i) begin
      left_q <= '0;
    end else if (match_o) begin
      left_q <= SC_W'(STB_LEN);
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign strobe_o = (left_q != '0);

  // R6: captured value only changes on a start command
  p_cap_stable_r6: assert property (@(posedge clk) disable iff (rst)
    !start_i |=> $stable(cap_q));
  // R2: a strobe that starts lasts beyond its first cycle
  p_strobe_width_r2: assert property (@(posedge clk) disable iff (rst)
    ($rose(strobe_o) && !start_i) |-> ##1 (strobe_o || $past(start_i)));
endmodule

// File: rtl/pwg_out_latch.sv
module pwg_out_latch (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic set_i,
  input  logic clr_i,
  output logic pulse_o,
  output logic done_o
);
  logic pulse_q;
  logic done_q;

  always_ff @(posedge clk) begin
    if (rst || start_i) begin
      pulse_q <= 1'b0;
      done_q  <= 1'b0;
    end else if (clr_i) begin
      pulse_q <= 1'b0;
      done_q  <= 1'b1;
    end else if (set_i) begin
      pulse_q <= 1'b1;
    end
  end

  assign pulse_o = pulse_q;
  assign done_o  = done_q;

  // R4: clear beats set when both strobes are present
  p_clear_wins_r4: assert property (@(posedge clk) disable iff (rst)
    (set_i && clr_i && !start_i) |=> !pulse_q);
  // R7: done and pulse are never high together
  p_done_excl_r7: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !pulse_q);
  // R7: done holds until a start
  p_done_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (done_q && !start_i) |=> done_q);
  // R8: start forces the output low
  p_start_low_r8: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (!pulse_q && !done_q));
endmodule

// File: rtl/pulse_window_gen.sv
module pulse_window_gen #(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned DIV     = 4,
  parameter int unsigned STB_LEN = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [CNT_W-1:0] start_val_i,
  input  logic [CNT_W-1:0] end_val_i,
  output logic             pulse_o,
  output logic             done_o
);
  import pwg_pkg::*;

  logic             tick;
  logic             phase0;
  logic             running;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] ch_val   [PWG_NUM_CH];
  logic             ch_match [PWG_NUM_CH];
  logic             ch_stb   [PWG_NUM_CH];

  assign ch_val[CH_SET] = start_val_i;
  assign ch_val[CH_CLR] = end_val_i;

  pwg_tick_div #(.DIV(DIV)) u_div (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .running_i(running),
    .tick_o   (tick),
    .phase0_o (phase0)
  );

  pwg_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .tick_i   (tick),
    .stop_i   (ch_match[CH_CLR]),
    .running_o(running),
    .count_o  (count)
  );

  for (genvar g = 0; g < PWG_NUM_CH; g++) begin : g_ch
    pwg_cmp_strobe #(.CNT_W(CNT_W), .STB_LEN(STB_LEN)) u_cmp (
      .clk      (clk),
      .rst      (rst),
      .start_i  (start_i),
      .val_i    (ch_val[g]),
      .count_i  (count),
      .phase0_i (phase0),
      .running_i(running),
      .match_o  (ch_match[g]),
      .strobe_o (ch_stb[g])
    );
  end

  pwg_out_latch u_out (
    .clk    (clk),
    .rst    (rst),
    .start_i(start_i),
    .set_i  (ch_stb[CH_SET]),
    .clr_i  (ch_stb[CH_CLR]),
    .pulse_o(pulse_o),
    .done_o (done_o)
  );

  // R1: reset leaves both outputs low
  p_reset_low_r1: assert property (@(posedge clk)
    rst |=> (!pulse_o && !done_o));
endmodule

// File: tb/test_pulse_window_gen.sv
module test_pulse_window_gen;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start_i = 1'b0;
  logic [CNT_W-1:0] start_val_i = '0;
  logic [CNT_W-1:0] end_val_i = '0;
  logic             pulse_o;
  logic             done_o;

  int n_checks = 0;
  int n_fails  = 0;

  always #2 clk = ~clk;

  pulse_window_gen #(.CNT_W(CNT_W)) i_pulse_window_gen (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .start_val_i(start_val_i),
    .end_val_i  (end_val_i),
    .pulse_o    (pulse_o),
    .done_o     (done_o)
  );

  function automatic logic exp_pulse(int a, int b, int t);
    return (a < b) && (t >= 4*a + 2) && (t < 4*b + 2);
  endfunction

  function automatic logic exp_done(int b, int t);
    return t >= 4*b + 2;
  endfunction

  // Starts a window (a,b) at the current negedge and checks n cycles.
  // At cycle chg_t (if >= 0) the value inputs are rewritten to (9,1).
  task automatic run_window(int a, int b, int n, int chg_t, string tag);
    int bad = 0;
    logic ap = 1'b0, ad = 1'b0, ep = 1'b0, ed = 1'b0;
    int bt = -1;
    start_val_i = CNT_W'(a);
    end_val_i   = CNT_W'(b);
    start_i     = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int t = 0; t < n; t++) begin
      if (t == chg_t) begin
        start_val_i = CNT_W'(9);
        end_val_i   = CNT_W'(1);
      end
      if (pulse_o !== exp_pulse(a, b, t) || done_o !== exp_done(b, t)) begin
        if (bad == 0) begin
          bt = t; ap = pulse_o; ad = done_o;
          ep = exp_pulse(a, b, t); ed = exp_done(b, t);
        end
        bad++;
      end
      @(negedge clk);
    end
    n_checks++;
    if (bad != 0) begin
      n_fails++;
      $display("FAIL %s a=%0d b=%0d cycle %0d: pulse/done actual %b/%b expected %b/%b",
               tag, a, b, bt, ap, ad, ep, ed);
    end
  endtask

  initial begin
    #(4 * 200000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs low during and after reset
    n_checks++;
    if (pulse_o !== 1'b0 || done_o !== 1'b0) begin
      n_fails++;
      $display("FAIL R1 in reset: actual %b/%b expected 0/0", pulse_o, done_o);
    end
    rst = 1'b0;
    repeat (5) @(negedge clk);
    n_checks++;
    if (pulse_o !== 1'b0 || done_o !== 1'b0) begin
      n_fails++;
      $display("FAIL R1 idle: actual %b/%b expected 0/0", pulse_o, done_o);
    end

    // R2 R3 R4 R5 R7: exhaustive sweep of small start/end pairs
    for (int a = 0; a <= 5; a++) begin
      for (int b = 0; b <= 5; b++) begin
        run_window(a, b, 4*b + 12, -1,
                   (a < b) ? "R2/R3" : ((a == b) ? "R4" : "R5"));
      end
    end

    // R6: inputs rewritten mid-pulse must not matter
    run_window(2, 6, 40, 12, "R6");

    // R7: long idle after done keeps done high
    run_window(1, 3, 120, -1, "R7");

    // R8: restart while pulse is high, then new window timing
    run_window(1, 8, 11, -1, "R8 first");
    run_window(3, 4, 30, -1, "R8 restart");
    run_window(0, 2, 20, -1, "R8 after");

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule